// File: doc/BRIEF.md
# Register-Pair Hardware Multiplier

This unit performs an unsigned multiply for an 8-bit processor datapath. The two factors come from the processor's B and C registers. The double-width product is returned so that the caller can write it back over the same register pair: the upper half goes to B and the lower half goes to C. Instruction decode, register-file writeback and bus timing are handled outside the block. The caller pulses `start` with the operands and the current flag byte. It then waits for `done`, a one-cycle pulse. The product and the updated flag byte are valid in the same cycle as `done`.

The multiply uses one shift-and-add step per clock, one step per operand bit. One more cycle registers the result and the flags. This gives a fixed latency, well inside the 14-cycle budget for extended operations. The operation belongs to the extended instruction set. When the `EXT_ENABLE` parameter is 0, the unit never starts.

Top module: `reg_pair_mult`

## Requirements
- R1: After a clock edge with `rst_n` low, `done` and `busy` are 0, and `product` and `flags_out` are all zeros.
- R2: `product` equals `op_b * op_c` as unsigned numbers, with bits 15..8 holding the B half and bits 7..0 holding the C half.
- R3: `done` goes high for exactly one cycle, 9 clock edges after the edge that accepts `start`. `busy` is high from that accepting edge until `done` rises.
- R4: The whole operation, counted from the accepting edge to the `done` cycle, takes no more than 14 clock cycles.
- R5: Flag bit 7 (sign) of `flags_out` equals product bit 15.
- R6: Flag bit 6 (zero) of `flags_out` is 1 exactly when the full 16-bit product is zero.
- R7: Flag bit 5 (unsigned indicator) of `flags_out` is set to 1.
- R8: Flag bit 3 (operation type) of `flags_out` is cleared to 0.
- R9: Flag bits 4, 2, 1 and 0 of `flags_out` copy the same bits of `flags_in` as sampled at the accepting edge.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running operation completes with its original operands, and no extra `done` pulse follows.
- R11: The operands and `flags_in` are sampled only at the accepting edge. Later changes to them do not affect the result.
- R12: With `EXT_ENABLE` = 0, `start` has no effect: `busy` and `done` stay 0 and `product` stays zero.
- R13: `product` and `flags_out` hold their values after `done` until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse, accepted only when idle |
| op_b | input | WIDTH | B register contents (multiplicand) |
| op_c | input | WIDTH | C register contents (multiplier) |
| flags_in | input | 8 | Flag byte at the time of the request |
| product | output | 2*WIDTH | Product; high half for B, low half for C |
| flags_out | output | 8 | Updated flag byte |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
The bench tests the extreme products. 255 x 255 is the largest operand pair and sets the sign flag. A zero in either factor is the only case that sets the zero flag. A design that kept only the low byte, or tested zero on only one half, gets these cases wrong. The bench sends a second `start` in the middle of an operation. A unit that reloads on that pulse returns the second product or a second `done`. The bench also changes the operands and `flags_in` right after the accepting edge. A unit that samples them late, or passes `flags_in` straight through, gives wrong result bits or wrong preserved flags. The bench counts the latency edge by edge. A step counter that is off by one moves `done` or truncates the last partial product.

// File: rtl/mulu_pkg.sv
// Package: shared state encoding and flag-byte bit positions for the
// register-pair multiplier. Assumes an 8-bit flag byte.
package mulu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_e;

    localparam int FLAG_W    = 8;
    localparam int FL_SIGN   = 7;
    localparam int FL_ZERO   = 6;
    localparam int FL_UNS    = 5;
    localparam int FL_OPTYPE = 3;

endpackage

// File: rtl/mulu_ctrl.sv
// Sequencer: accepts a request only when idle, runs one step per operand
// bit, then spends one finishing cycle and issues a registered done pulse.
// Assumes start is already gated by the compile-time enable.
module mulu_ctrl
    import mulu_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int MAX_CYCLES = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic fin_o,
    output logic done_o,
    output logic busy_o
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam int LW = $clog2(2 * WIDTH + MAX_CYCLES + 4);
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    mul_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic [LW-1:0] lat_q;

    assign load_o = (state_q == ST_IDLE) && start_i;
    assign step_o = (state_q == ST_STEP);
    assign fin_o  = (state_q == ST_FIN);
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;

    // State and step counter advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_STEP;
                    cnt_q   <= '0;
                end
                ST_STEP: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_STEP) state_q <= ST_FIN;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Completion pulse, one cycle after the finishing state
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= fin_o;
    end

    // Latency tracker, used only by the cycle-budget check
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= '0;
        else if (load_o) lat_q <= LW'(1);
        else if (busy_o) lat_q <= lat_q + 1'b1;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
    AST_CYCLE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q <= LW'(MAX_CYCLES))); // R4
    AST_FIN_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> $past(step_o)); // R3
    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !fin_o) |=> busy_o); // R10

endmodule

// File: rtl/mulu_shift_add.sv
// Datapath: radix-2 shift-and-add multiply. On load the multiplier sits in
// the low half of the accumulator; each step adds the multiplicand into
// the high half when the current multiplier bit is 1, then shifts right.
// Assumes unsigned operands and exactly WIDTH step cycles.
module mulu_shift_add #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic               fin_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic [2*WIDTH-1:0] acc_o,
    output logic [2*WIDTH-1:0] prod_o
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [PW-1:0]    acc_q;
    logic [PW-1:0]    prod_q;
    logic [WIDTH:0]   sum;

    // Partial sum of the high half with the gated multiplicand
    always_comb begin
        sum = {1'b0, acc_q[PW-1:WIDTH]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
    end

    // Operand capture and one shift-add step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
        end else if (load_i) begin
            mcand_q <= mcand_i;
            acc_q   <= {{WIDTH{1'b0}}, mplier_i};
        end else if (step_i) begin
            acc_q   <= {sum, acc_q[WIDTH-1:1]};
        end
    end

    // Result register, updated only at the finishing cycle
    always_ff @(posedge clk) begin
        if (!rst_n)     prod_q <= '0;
        else if (fin_i) prod_q <= acc_q;
    end

    assign acc_o  = acc_q;
    assign prod_o = prod_q;

    AST_MCAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> $stable(mcand_q)); // R11
    AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_i |=> $stable(prod_q)); // R13

endmodule

// File: rtl/mulu_flag_merge.sv
// Flag update: saves the incoming flag byte at load, then at the finishing
// cycle writes sign, zero and unsigned-indicator from the product, clears
// the operation-type bit and keeps every other bit as saved.
module mulu_flag_merge
    import mulu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                fin_i,
    input  logic [FLAG_W-1:0]   flags_i,
    input  logic [2*WIDTH-1:0]  result_i,
    output logic [FLAG_W-1:0]   flags_o
);
    logic [FLAG_W-1:0] saved_q;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] merged;

    // Merge the result-derived bits into the saved byte
    always_comb begin
        merged            = saved_q;
        merged[FL_SIGN]   = result_i[2*WIDTH-1];
        merged[FL_ZERO]   = (result_i == '0);
        merged[FL_UNS]    = 1'b1;
        merged[FL_OPTYPE] = 1'b0;
    end

    // Capture the flag byte when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)      saved_q <= '0;
        else if (load_i) saved_q <= flags_i;
    end

    // Publish the updated flags at the finishing cycle
    always_ff @(posedge clk) begin
        if (!rst_n)     flags_q <= '0;
        else if (fin_i) flags_q <= merged;
    end

    assign flags_o = flags_q;

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_i |=> $stable(flags_q)); // R13

endmodule

// File: rtl/reg_pair_mult.sv
// Top: register-pair multiplier. Multiplies B by C, returns the double-width
// product for writeback over BC, and an updated flag byte with a done pulse.
// Assumes the caller holds no expectation of results before done.
module reg_pair_mult
    import mulu_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int MAX_CYCLES = 14,
    parameter bit EXT_ENABLE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WIDTH-1:0]     op_b,
    input  logic [WIDTH-1:0]     op_c,
    input  logic [FLAG_W-1:0]    flags_in,
    output logic [2*WIDTH-1:0]   product,
    output logic [FLAG_W-1:0]    flags_out,
    output logic                 done,
    output logic                 busy
);
    logic                 start_ok;
    logic                 load, step, fin;
    logic [2*WIDTH-1:0]   acc;

    // Compile-time gate for the extended operation
    generate
        if (EXT_ENABLE) begin : g_ext_on
            assign start_ok = start;
        end else begin : g_ext_off
            assign start_ok = 1'b0;
            AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !busy && !done); // R12
        end
    endgenerate

    mulu_ctrl #(.WIDTH(WIDTH), .MAX_CYCLES(MAX_CYCLES)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_ok),
        .load_o (load),
        .step_o (step),
        .fin_o  (fin),
        .done_o (done),
        .busy_o (busy)
    );

    mulu_shift_add #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .fin_i   (fin),
        .mcand_i (op_b),
        .mplier_i(op_c),
        .acc_o   (acc),
        .prod_o  (product)
    );

    mulu_flag_merge #(.WIDTH(WIDTH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .fin_i   (fin),
        .flags_i (flags_in),
        .result_i(acc),
        .flags_o (flags_out)
    );

    AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[FL_SIGN] == product[2*WIDTH-1])); // R5
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[FL_ZERO] == (product == '0))); // R6
    AST_UNS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> flags_out[FL_UNS]); // R7
    AST_OPTYPE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flags_out[FL_OPTYPE]); // R8
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R3

endmodule

// File: tb/tb_reg_pair_mult.sv
module tb_reg_pair_mult;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_b = '0, op_c = '0, flags_in = '0;
    logic [15:0] product, off_product;
    logic [7:0]  flags_out, off_flags;
    logic        done, busy, off_done, off_busy;

    int checks = 0;
    int errors = 0;
    bit off_seen = 1'b0;
    bit done_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_pair_mult dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_b(op_b), .op_c(op_c),
        .flags_in(flags_in), .product(product), .flags_out(flags_out),
        .done(done), .busy(busy)
    );

    reg_pair_mult #(.EXT_ENABLE(1'b0)) dut_off (
        .clk(clk), .rst_n(rst_n), .start(start), .op_b(op_b), .op_c(op_c),
        .flags_in(flags_in), .product(off_product), .flags_out(off_flags),
        .done(off_done), .busy(off_busy)
    );

    // Sticky monitor for the disabled instance (R12)
    always @(posedge clk) if (rst_n && (off_done || off_busy)) off_seen <= 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_flags(input logic [7:0] f, input logic [15:0] p);
        logic [7:0] e = f;
        e[7] = p[15];
        e[6] = (p == 16'h0);
        e[5] = 1'b1;
        e[3] = 1'b0;
        return e;
    endfunction

    // One full operation; optional mid-run second start; operands scrambled after accept
    task automatic run_mult(input logic [7:0] b, input logic [7:0] c, input logic [7:0] f,
                            input bit inject, input string tag);
        int lat = 0;
        logic [15:0] p = 16'(b) * 16'(c);
        @(negedge clk);
        op_b = b; op_c = c; flags_in = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_b = ~b; op_c = c ^ 8'h5A; flags_in = ~f;               // R11 scramble
        chk({tag, " R3 busy after accept"}, busy, 1);
        while (!done && lat < 20) begin
            if (inject && lat == 3) begin start = 1'b1; op_b = 8'h03; op_c = 8'h07; end // R10
            else start = 1'b0;
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk({tag, " R3 latency"}, lat, 9);
        chk({tag, " R4 within budget"}, (lat + 1 <= 14), 1);
        chk({tag, " R2 R11 product"}, product, p);
        chk({tag, " R5 R6 R7 R8 R9 flags"}, flags_out, exp_flags(f, p));
        @(negedge clk);
        chk({tag, " R3 single pulse"}, done, 0);
        chk({tag, " R3 idle after done"}, busy, 0);
    endtask

    task automatic t_reset();
        chk("R1 done", done, 0);
        chk("R1 busy", busy, 0);
        chk("R1 product", product, 0);
        chk("R1 flags", flags_out, 0);
    endtask

    task automatic t_busy_ignore();
        run_mult(8'd200, 8'd150, 8'h17, 1'b1, "R10 mid-run start");
        done_seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) done_seen = 1'b1;
        end
        chk("R10 no extra done", done_seen, 0);
    endtask

    task automatic t_hold();
        logic [15:0] p = product;
        logic [7:0]  f = flags_out;
        op_b = 8'h99; op_c = 8'h88; flags_in = 8'h00;
        repeat (5) @(negedge clk);
        chk("R13 product held", product, p);
        chk("R13 flags held", flags_out, f);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        run_mult(8'd12,  8'd13,  8'h00, 1'b0, "R2 basic");
        run_mult(8'd255, 8'd255, 8'h08, 1'b0, "R5 max sign");
        run_mult(8'd0,   8'd200, 8'hFF, 1'b0, "R6 zero b");
        run_mult(8'd77,  8'd0,   8'h15, 1'b0, "R6 zero c");
        run_mult(8'd1,   8'd129, 8'hEA, 1'b0, "R9 identity");
        run_mult(8'd128, 8'd2,   8'h97, 1'b0, "R2 high byte only");
        t_busy_ignore();
        t_hold();
        chk("R12 disabled never active", off_seen, 0);
        chk("R12 disabled product", off_product, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule